// File: doc/BRIEF.md
# Wiper Position Counter with Tap Decode

This block holds the position of one potentiometer wiper as an 8-bit code and turns that code into a one-hot select vector for the 256 tap switches of a resistor string. Tap 0 sits at the low terminal and tap 255 at the high terminal. The decoded vector is the boundary of the block, and the analog array lies outside it.

The position can change in four ways. A host byte can be written in through the serial path. A parallel copy can be taken from one of four stored bank registers. A single step can be taken up or down while step mode is armed. A one-time recall from bank 0 happens once the supplies are reported stable after reset. In step mode, every low-to-high transition of the bus clock line moves the wiper by one tap. The direction comes from the bus data line as sampled at that transition.

Bus lines arrive already synchronised to `clk`. A rising edge of the bus clock line is recognised in the cycle where it is first sampled high. That edge acts at the same `clk` edge, as do the loads and the recall.

Top module: `tap_wiper_unit`

## Requirements
- R1: `tap_sel` has exactly one bit set at all times, and that bit's index equals `wiper_code`.
- R2: Code 8'h00 drives bit 0 (low terminal end) and code 8'hFF drives bit 255 (high terminal end).
- R3: After reset the code is 8'h00 and `recalled` is low. Host loads, bank loads and steps have no effect on the code until the recall has taken place.
- R4: At the first clock edge after reset that samples `supply_ok` high, the code takes the value of bank 0 (`bank_regs[7:0]`) and `recalled` goes high. Later changes of `supply_ok` or bank 0 cause no further recall.
- R5: With `host_load` high at a clock edge, the code becomes `host_byte` at that edge.
- R6: With `bank_load` high at a clock edge, the code becomes bank `bank_sel`, taken from `bank_regs[8*bank_sel+7 : 8*bank_sel]`.
- R7: With `step_arm` high, an edge at which `bus_scl` is sampled high after being sampled low steps the code by +1 if `bus_sda` is high and by -1 if it is low. With `step_arm` low, edges of `bus_scl` do nothing.
- R8: A step up at 8'hFF and a step down at 8'h00 leave the code unchanged.
- R9: Priority within one edge is recall, then host load, then bank load, then step.
- R10: Holding `bus_scl` high for several cycles gives a single step. With no request, the code is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | All supplies stable; triggers the one-time recall |
| bank_regs | input | 32 | Four stored bytes, bank i at bits [8i+7:8i] |
| bank_sel | input | 2 | Bank chosen for a parallel load |
| bank_load | input | 1 | Parallel load strobe |
| host_byte | input | 8 | Byte from the serial path |
| host_load | input | 1 | Serial-path load strobe |
| step_arm | input | 1 | Step mode enabled |
| bus_scl | input | 1 | Synchronised bus clock line |
| bus_sda | input | 1 | Synchronised bus data line (step direction) |
| wiper_code | output | 8 | Current wiper position |
| tap_sel | output | 256 | One-hot tap switch enables |
| recalled | output | 1 | Power-up recall has taken place |

## Verification
The embedded properties watch the following on every cycle:
- the one-hot tap vector and its agreement with the code;
- the one-time recall from bank 0;
- the results of host and bank loads;
- single-step increments and decrements, saturation at both ends, and holding when idle;
- step requests appearing only when step mode is armed and never two cycles in a row.

Other behaviours need the bench's scenarios:
- loads and steps being ignored before recall;
- no second recall when the supply flag toggles;
- the full 256-code decode sweep;
- full-range stepping in both directions;
- the priority order when several requests share one edge.

// File: rtl/tap_wiper_pkg.sv
`timescale 1ns/1ps
package tap_wiper_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD   = 3'd0,
    ACT_RECALL = 3'd1,
    ACT_HOST   = 3'd2,
    ACT_BANK   = 3'd3,
    ACT_INC    = 3'd4,
    ACT_DEC    = 3'd5
  } wiper_act_e;
endpackage

// File: rtl/tap_step_detect.sv
`timescale 1ns/1ps
module tap_step_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic scl,
  input  logic sda,
  output logic step_req,
  output logic step_up
);
  logic scl_q, scl_d;

  always_comb begin
    scl_d    = scl;
    step_req = arm && scl && !scl_q;
    step_up  = sda;
  end

  // reset to high so a line already high at reset release is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl_d;
  end

  assert_step_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |-> arm);
  assert_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |=> !step_req);
endmodule

// File: rtl/tap_action_arb.sv
`timescale 1ns/1ps
module tap_action_arb
  import tap_wiper_pkg::*;
(
  input  logic       supply_ok,
  input  logic       recalled,
  input  logic       host_load,
  input  logic       bank_load,
  input  logic       step_req,
  input  logic       step_up,
  output wiper_act_e action
);
  always_comb begin
    action = ACT_HOLD;
    if (!recalled) begin
      if (supply_ok) action = ACT_RECALL;
    end else if (host_load) begin
      action = ACT_HOST;
    end else if (bank_load) begin
      action = ACT_BANK;
    end else if (step_req) begin
      action = step_up ? ACT_INC : ACT_DEC;
    end
  end
endmodule

// File: rtl/tap_pos_reg.sv
`timescale 1ns/1ps
module tap_pos_reg
  import tap_wiper_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wiper_act_e       action,
  input  logic [WIDTH-1:0] host_byte,
  input  logic [WIDTH-1:0] bank_byte,
  input  logic [WIDTH-1:0] recall_byte,
  output logic [WIDTH-1:0] code,
  output logic             recalled
);
  localparam logic [WIDTH-1:0] CODE_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] CODE_MIN = '0;

  logic [WIDTH-1:0] code_q, code_d;
  logic             rec_q, rec_d;
  logic             code_en;

  always_comb begin
    code_d  = code_q;
    rec_d   = rec_q;
    code_en = 1'b1;
    unique case (action)
      ACT_RECALL: begin code_d = recall_byte; rec_d = 1'b1; end
      ACT_HOST:   code_d = host_byte;
      ACT_BANK:   code_d = bank_byte;
      ACT_INC:    code_d = (code_q == CODE_MAX) ? code_q : code_q + WIDTH'(1);
      ACT_DEC:    code_d = (code_q == CODE_MIN) ? code_q : code_q - WIDTH'(1);
      default:    code_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      rec_q  <= 1'b0;
    end else if (code_en) begin
      code_q <= code_d;
      rec_q  <= rec_d;
    end
  end

  assign code     = code_q;
  assign recalled = rec_q;

  assert_recall_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_RECALL) |=> (code_q == $past(recall_byte)) && rec_q);
  assert_recall_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_q |=> rec_q);
  assert_idle_before_recall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_q |-> (code_q == CODE_MIN));
  assert_step_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_INC && code_q != CODE_MAX) |=> code_q == WIDTH'($past(code_q) + 1'b1));
  assert_step_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_DEC && code_q != CODE_MIN) |=> code_q == WIDTH'($past(code_q) - 1'b1));
  assert_sat_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_INC && code_q == CODE_MAX) |=> code_q == CODE_MAX);
  assert_sat_bottom_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_DEC && code_q == CODE_MIN) |=> code_q == CODE_MIN);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_HOLD) |=> $stable(code_q));
endmodule

// File: rtl/tap_onehot_dec.sv
`timescale 1ns/1ps
module tap_onehot_dec #(
  parameter int WIDTH = 8,
  localparam int TAPS = 1 << WIDTH
) (
  input  logic [WIDTH-1:0] code,
  output logic [TAPS-1:0]  sel
);
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign sel[t] = (code == WIDTH'(t));
  end
endmodule

// File: rtl/tap_wiper_unit.sv
`timescale 1ns/1ps
module tap_wiper_unit
  import tap_wiper_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int NUM_BANKS = 4,
  localparam int SEL_W    = $clog2(NUM_BANKS),
  localparam int TAPS     = 1 << WIDTH
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       supply_ok,
  input  logic [NUM_BANKS*WIDTH-1:0] bank_regs,
  input  logic [SEL_W-1:0]           bank_sel,
  input  logic                       bank_load,
  input  logic [WIDTH-1:0]           host_byte,
  input  logic                       host_load,
  input  logic                       step_arm,
  input  logic                       bus_scl,
  input  logic                       bus_sda,
  output logic [WIDTH-1:0]           wiper_code,
  output logic [TAPS-1:0]            tap_sel,
  output logic                       recalled
);
  logic             step_req, step_up;
  wiper_act_e       action;
  logic [WIDTH-1:0] bank_pick, bank_zero;

  assign bank_pick = bank_regs[bank_sel*WIDTH +: WIDTH];
  assign bank_zero = bank_regs[WIDTH-1:0];

  tap_step_detect u_step (
    .clk(clk), .rst_n(rst_n), .arm(step_arm), .scl(bus_scl), .sda(bus_sda),
    .step_req(step_req), .step_up(step_up)
  );

  tap_action_arb u_arb (
    .supply_ok(supply_ok), .recalled(recalled), .host_load(host_load),
    .bank_load(bank_load), .step_req(step_req), .step_up(step_up),
    .action(action)
  );

  tap_pos_reg #(.WIDTH(WIDTH)) u_pos (
    .clk(clk), .rst_n(rst_n), .action(action), .host_byte(host_byte),
    .bank_byte(bank_pick), .recall_byte(bank_zero),
    .code(wiper_code), .recalled(recalled)
  );

  tap_onehot_dec #(.WIDTH(WIDTH)) u_dec (
    .code(wiper_code), .sel(tap_sel)
  );

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap_sel) == 1) && tap_sel[wiper_code]);
  assert_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_sel[0] == (wiper_code == '0)) && (tap_sel[TAPS-1] == (wiper_code == {WIDTH{1'b1}})));
  assert_host_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (recalled && host_load) |=> wiper_code == $past(host_byte));
  assert_bank_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (recalled && !host_load && bank_load) |=> wiper_code == $past(bank_pick));
  assert_load_over_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (recalled && host_load && step_req) |=> wiper_code == $past(host_byte));
endmodule

// File: tb/tap_wiper_unit_tb.sv
`timescale 1ns/1ps
module tap_wiper_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         supply_ok;
  logic [31:0]  bank_regs;
  logic [1:0]   bank_sel;
  logic         bank_load;
  logic [7:0]   host_byte;
  logic         host_load;
  logic         step_arm;
  logic         bus_scl;
  logic         bus_sda;
  logic [7:0]   wiper_code;
  logic [255:0] tap_sel;
  logic         recalled;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  tap_wiper_unit u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .bank_regs(bank_regs),
    .bank_sel(bank_sel), .bank_load(bank_load), .host_byte(host_byte),
    .host_load(host_load), .step_arm(step_arm), .bus_scl(bus_scl),
    .bus_sda(bus_sda), .wiper_code(wiper_code), .tap_sel(tap_sel),
    .recalled(recalled)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] exp, input logic exp_rec);
    logic [255:0] exp_sel;
    exp_sel = 256'b1 << exp;
    checks++;
    if (wiper_code !== exp || tap_sel !== exp_sel || recalled !== exp_rec) begin
      errors++;
      $display("FAIL %s: code=%h rec=%b onehot_ok=%b expected code=%h rec=%b",
               tag, wiper_code, recalled, (tap_sel === exp_sel), exp, exp_rec);
    end
  endtask

  task automatic step(input logic dir);
    bus_scl = 1'b1; bus_sda = dir;
    cyc();
  endtask

  task automatic scl_low();
    bus_scl = 1'b0;
    cyc();
  endtask

  initial begin
    logic [7:0] e;
    rst_n = 1'b0; supply_ok = 1'b0; bank_regs = 32'h44_33_22_5A; bank_sel = 2'd0;
    bank_load = 1'b0; host_byte = 8'h00; host_load = 1'b0; step_arm = 1'b0;
    bus_scl = 1'b0; bus_sda = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    check("R3 reset state", 8'h00, 1'b0);

    // R3: requests before recall are ignored
    host_byte = 8'h77; host_load = 1'b1; cyc(); host_load = 1'b0;
    check("R3 host load before recall", 8'h00, 1'b0);
    bank_sel = 2'd2; bank_load = 1'b1; cyc(); bank_load = 1'b0;
    check("R3 bank load before recall", 8'h00, 1'b0);
    step_arm = 1'b1; step(1'b1); scl_low(); step_arm = 1'b0;
    check("R3 step before recall", 8'h00, 1'b0);

    // R4: recall from bank 0
    supply_ok = 1'b1; cyc();
    check("R4 recall bank0", 8'h5A, 1'b1);
    bank_regs[7:0] = 8'hC3; supply_ok = 1'b0; cyc(); supply_ok = 1'b1; cyc();
    check("R4 no second recall", 8'h5A, 1'b1);

    // R5 / R1 / R2: host load sweep over all codes
    for (int v = 0; v < 256; v++) begin
      host_byte = 8'(v); host_load = 1'b1; cyc();
      check((v == 0 || v == 255) ? "R2 end tap" : "R5 R1 host load", 8'(v), 1'b1);
    end
    host_load = 1'b0;
    cyc();
    check("R10 hold idle", 8'hFF, 1'b1);

    // R6: each bank
    bank_regs = 32'h9E_61_13_C3;
    for (int b = 0; b < 4; b++) begin
      bank_sel = 2'(b); bank_load = 1'b1; cyc();
      check("R6 bank load", bank_regs[b*8 +: 8], 1'b1);
    end
    bank_load = 1'b0;

    // R7 / R8: full-range stepping
    host_byte = 8'h00; host_load = 1'b1; cyc(); host_load = 1'b0;
    step_arm = 1'b1;
    e = 8'h00;
    for (int i = 0; i < 260; i++) begin
      step(1'b1);
      e = (e == 8'hFF) ? e : e + 8'd1;
      check((i >= 255) ? "R8 saturate top" : "R7 step up", e, 1'b1);
      scl_low();
    end
    for (int i = 0; i < 260; i++) begin
      step(1'b0);
      e = (e == 8'h00) ? e : e - 8'd1;
      check((i >= 255) ? "R8 saturate bottom" : "R7 step down", e, 1'b1);
      scl_low();
    end

    // R10: scl held high gives one step
    host_byte = 8'h40; host_load = 1'b1; cyc(); host_load = 1'b0;
    step(1'b1); cyc(); cyc(); cyc();
    check("R10 single step while held", 8'h41, 1'b1);
    scl_low();

    // R7: unarmed edges ignored
    step_arm = 1'b0;
    step(1'b1); scl_low(); step(1'b0); scl_low();
    check("R7 unarmed ignored", 8'h41, 1'b1);

    // R9: priority
    step_arm = 1'b1;
    host_byte = 8'h10; host_load = 1'b1; bank_sel = 2'd3; bank_load = 1'b1;
    step(1'b1);
    check("R9 host over bank and step", 8'h10, 1'b1);
    host_load = 1'b0; scl_low();
    step(1'b0);
    check("R9 bank over step", 8'h9E, 1'b1);
    bank_load = 1'b0; scl_low();
    step(1'b0);
    check("R7 step after loads", 8'h9D, 1'b1);
    scl_low();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule